// File: doc/BRIEF.md
# Link bring-up and Gen2 recovery monitor

This block brings a serial-link controller out of reset and then watches the link. After reset it holds the PHY in reset and power-down while the reference clocks settle. It then releases the PHY and holds the endpoint reset (PERST#, active low) for a short time. After that it waits a hold-off period so the endpoint can initialise itself. Only then does it raise the training enable of the link state machine. All of these durations are counted in pulses of a one-millisecond tick input.

While training is enabled, the block decodes link-up from two bits of a 32-bit debug status word. If link-up does not appear within a poll limit, it latches a failure flag and drops the training enable. Once the link is up, a pulse on `gen2_start` marks the start of a speed change. Two milliseconds later the block compares the link state code from the low six bits of the other debug word with the PHY receive-valid signal. If the link state is in receiver-lock recovery and receive-valid is low, the speed change is stuck. The block then asks the PHY register path to force the receiver data-enable and PLL-enable overrides on. It holds them for a set time and then asks for them to be cleared. The PHY register path is outside this block and is reached by a request/done handshake.

Top module: `link_bringup_mon`

## Requirements
- R1: `link_up` is high in the cycle after an edge at which training is enabled (training phase or link-up phase) and `dbg_word1` bit 4 is 1 and bit 29 is 0. Otherwise it is low. The transition to the link-up phase happens at that same edge.
- R2: After reset, `phy_rst` and `phy_pwrdn` are high, `perst_n` is low and `ltssm_en` is low. This holds until SETTLE_MS (30) tick pulses have been counted.
- R3: Next, `phy_rst` and `phy_pwrdn` are low and `perst_n` stays low for PERST_MS (1) tick pulses.
- R4: Next, `perst_n` is high and `ltssm_en` stays low for HOLDOFF_MS (20) tick pulses.
- R5: After the hold-off, `ltssm_en` is high. It stays high through training and after link-up.
- R6: If POLL_MS (200) tick pulses pass in training without link-up, `link_fail` goes high and stays high until reset, and `ltssm_en` goes low. Link-up seen at an edge wins over an expiring tick at the same edge.
- R7: A `gen2_start` pulse in the link-up phase starts a wait of GEN2_WAIT_MS (2) tick pulses. At the edge of the last of these pulses, the speed change is stuck if `dbg_word0[5:0]` equals 0x0D and `phy_rx_valid` is 0.
- R8: When stuck, `ovr_req` is high with `ovr_en` = 2'b11 (bit 1 receive-data enable, bit 0 receive-PLL enable) until an edge with `ovr_done` high.
- R9: `ovr_en` then stays 2'b11 with `ovr_req` low for OVR_HOLD_MS (1) tick pulses. After that, `ovr_req` is high with `ovr_en` = 2'b00 until `ovr_done`, and the monitor returns to idle.
- R10: `gen2_start` has no effect outside the link-up phase or while a wait or override is in progress.
- R11: If the speed change is not stuck when the wait ends, no override request is made and the monitor returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| dbg_word0 | input | 32 | Debug word 0; bits 5:0 carry the link state code |
| dbg_word1 | input | 32 | Debug word 1; bit 4 link up, bit 29 in training |
| phy_rx_valid | input | 1 | PHY receive-valid |
| gen2_start | input | 1 | Pulse: a speed change to Gen2 has been started |
| ovr_done | input | 1 | PHY register path finished the current request |
| phy_rst | output | 1 | PHY reset, active high |
| phy_pwrdn | output | 1 | PHY power-down, active high |
| perst_n | output | 1 | Endpoint reset, active low |
| ltssm_en | output | 1 | Link training enable |
| link_up | output | 1 | Decoded link-up |
| link_fail | output | 1 | Link never came up within the poll limit |
| ovr_req | output | 1 | Request to write the receiver override bits |
| ovr_en | output | 2 | Override value to write: bit 1 data enable, bit 0 PLL enable |

## Verification
Several events can fall on the same clock edge:
- The millisecond tick that ends the Gen2 wait can coincide with a change of `phy_rx_valid` or of the link state code.
- A further `gen2_start` can arrive while an override is held.
- In training, link-up can appear on the same edge as the tick that would end the poll window.

The bench runs its tick from a free-running divider that is not aligned to the stimulus, so these edges line up in varying ways. A reference model built on countdowns judges every output on every cycle. It gives link-up priority over poll expiry, and it samples the stuck condition only on the expiring tick.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

  typedef enum logic [2:0] {
    SQ_SETTLE  = 3'd0,
    SQ_PERST   = 3'd1,
    SQ_HOLDOFF = 3'd2,
    SQ_TRAIN   = 3'd3,
    SQ_UP      = 3'd4,
    SQ_FAIL    = 3'd5
  } seq_st_t;

  typedef enum logic [2:0] {
    RV_IDLE = 3'd0,
    RV_WAIT = 3'd1,
    RV_SET  = 3'd2,
    RV_HOLD = 3'd3,
    RV_CLR  = 3'd4
  } rcv_st_t;

  localparam int          LINK_UP_BIT  = 4;
  localparam int          IN_TRAIN_BIT = 29;
  localparam logic [5:0]  RCVR_LOCK    = 6'h0D;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lbm_ms_timer.sv
module lbm_ms_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign done = tick && (cnt_q == limit - 1'b1);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: a running count never reaches the limit of its phase
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (cnt_q < limit));

endmodule

// File: rtl/lbm_reset_seq.sv
module lbm_reset_seq
  import lbm_pkg::*;
#(
  parameter int SETTLE_MS  = 30,
  parameter int PERST_MS   = 1,
  parameter int HOLDOFF_MS = 20,
  parameter int POLL_MS    = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic link_ok,
  output logic phy_rst,
  output logic phy_pwrdn,
  output logic perst_n,
  output logic ltssm_en,
  output logic link_fail,
  output logic link_up,
  output logic up_o
);

  localparam int MAX_MS = max2(max2(SETTLE_MS, PERST_MS), max2(HOLDOFF_MS, POLL_MS));
  localparam int CNT_W  = $clog2(MAX_MS + 1);

  seq_st_t          state_q, state_d;
  logic [CNT_W-1:0] limit;
  logic             t_done, t_clr;
  logic             link_up_q, link_up_d;

  lbm_ms_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(t_clr), .tick(ms_tick),
    .limit(limit), .done(t_done)
  );

  always_comb begin
    state_d = state_q;
    limit   = CNT_W'(POLL_MS);
    case (state_q)
      SQ_SETTLE: begin
        limit = CNT_W'(SETTLE_MS);
        if (t_done) state_d = SQ_PERST;
      end
      SQ_PERST: begin
        limit = CNT_W'(PERST_MS);
        if (t_done) state_d = SQ_HOLDOFF;
      end
      SQ_HOLDOFF: begin
        limit = CNT_W'(HOLDOFF_MS);
        if (t_done) state_d = SQ_TRAIN;
      end
      SQ_TRAIN: begin
        if (link_ok)     state_d = SQ_UP;
        else if (t_done) state_d = SQ_FAIL;
      end
      default: state_d = state_q;
    endcase
  end

  assign t_clr     = (state_d != state_q) || (state_q == SQ_UP) || (state_q == SQ_FAIL);
  assign link_up_d = ((state_q == SQ_TRAIN) || (state_q == SQ_UP)) && link_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SQ_SETTLE;
      link_up_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      link_up_q <= link_up_d;
    end
  end

  assign phy_rst   = (state_q == SQ_SETTLE);
  assign phy_pwrdn = (state_q == SQ_SETTLE);
  assign perst_n   = !((state_q == SQ_SETTLE) || (state_q == SQ_PERST));
  assign ltssm_en  = (state_q == SQ_TRAIN) || (state_q == SQ_UP);
  assign link_fail = (state_q == SQ_FAIL);
  assign link_up   = link_up_q;
  assign up_o      = (state_q == SQ_UP);

  p_train_after_perst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ltssm_en) |-> $past(perst_n));
  p_fail_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail |=> (link_fail && !ltssm_en));
  p_up_needs_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> ($past(ltssm_en) && $past(link_ok)));
  p_settle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phy_rst |-> (!perst_n && !ltssm_en));

endmodule

// File: rtl/lbm_gen2_recover.sv
module lbm_gen2_recover
  import lbm_pkg::*;
#(
  parameter int GEN2_WAIT_MS = 2,
  parameter int OVR_HOLD_MS  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       up_i,
  input  logic       gen2_start,
  input  logic [5:0] ltssm_code,
  input  logic       rx_valid,
  input  logic       ovr_done,
  output logic       ovr_req,
  output logic [1:0] ovr_en
);

  localparam int CNT_W = $clog2(max2(GEN2_WAIT_MS, OVR_HOLD_MS) + 1);

  rcv_st_t          state_q, state_d;
  logic [CNT_W-1:0] limit;
  logic             t_done, t_clr, stuck;

  lbm_ms_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(t_clr), .tick(ms_tick),
    .limit(limit), .done(t_done)
  );

  assign stuck = (ltssm_code == RCVR_LOCK) && !rx_valid;

  always_comb begin
    state_d = state_q;
    limit   = CNT_W'(GEN2_WAIT_MS);
    case (state_q)
      RV_IDLE: if (gen2_start && up_i) state_d = RV_WAIT;
      RV_WAIT: if (t_done) state_d = stuck ? RV_SET : RV_IDLE;
      RV_SET:  if (ovr_done) state_d = RV_HOLD;
      RV_HOLD: begin
        limit = CNT_W'(OVR_HOLD_MS);
        if (t_done) state_d = RV_CLR;
      end
      RV_CLR:  if (ovr_done) state_d = RV_IDLE;
      default: state_d = RV_IDLE;
    endcase
  end

  assign t_clr = (state_d != state_q) || !((state_q == RV_WAIT) || (state_q == RV_HOLD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RV_IDLE;
    else        state_q <= state_d;
  end

  assign ovr_req = (state_q == RV_SET) || (state_q == RV_CLR);
  assign ovr_en  = ((state_q == RV_SET) || (state_q == RV_HOLD)) ? 2'b11 : 2'b00;

  p_req_needs_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_req |-> up_i);
  p_clear_follows_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_en[0]) |-> (ovr_req && (ovr_en == 2'b00)));
  p_set_waits_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_req && ovr_en[1] && !ovr_done) |=> (ovr_req && ovr_en[1]));

endmodule

// File: rtl/link_bringup_mon.sv
module link_bringup_mon
  import lbm_pkg::*;
#(
  parameter int SETTLE_MS    = 30,
  parameter int PERST_MS     = 1,
  parameter int HOLDOFF_MS   = 20,
  parameter int POLL_MS      = 200,
  parameter int GEN2_WAIT_MS = 2,
  parameter int OVR_HOLD_MS  = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ms_tick,
  input  logic [31:0] dbg_word0,
  input  logic [31:0] dbg_word1,
  input  logic        phy_rx_valid,
  input  logic        gen2_start,
  input  logic        ovr_done,
  output logic        phy_rst,
  output logic        phy_pwrdn,
  output logic        perst_n,
  output logic        ltssm_en,
  output logic        link_up,
  output logic        link_fail,
  output logic        ovr_req,
  output logic [1:0]  ovr_en
);

  logic link_ok, up_phase, unused_bits;

  assign link_ok     = dbg_word1[LINK_UP_BIT] && !dbg_word1[IN_TRAIN_BIT];
  assign unused_bits = ^{dbg_word0[31:6], dbg_word1[31:30], dbg_word1[28:5], dbg_word1[3:0]};

  lbm_reset_seq #(
    .SETTLE_MS(SETTLE_MS), .PERST_MS(PERST_MS),
    .HOLDOFF_MS(HOLDOFF_MS), .POLL_MS(POLL_MS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .link_ok(link_ok),
    .phy_rst(phy_rst), .phy_pwrdn(phy_pwrdn), .perst_n(perst_n),
    .ltssm_en(ltssm_en), .link_fail(link_fail), .link_up(link_up),
    .up_o(up_phase)
  );

  lbm_gen2_recover #(
    .GEN2_WAIT_MS(GEN2_WAIT_MS), .OVR_HOLD_MS(OVR_HOLD_MS)
  ) u_rcv (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .up_i(up_phase),
    .gen2_start(gen2_start), .ltssm_code(dbg_word0[5:0]),
    .rx_valid(phy_rx_valid), .ovr_done(ovr_done),
    .ovr_req(ovr_req), .ovr_en(ovr_en)
  );

  p_fail_excludes_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail |-> !link_up);

endmodule

// File: tb/sim_link_bringup_mon.sv
module sim_link_bringup_mon;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ms_tick;
  logic [31:0] dbg_word0, dbg_word1;
  logic        phy_rx_valid, gen2_start, ovr_done;
  logic        phy_rst, phy_pwrdn, perst_n, ltssm_en, link_up, link_fail, ovr_req;
  logic [1:0]  ovr_en;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  int tdiv  = 0;
  int req_rises = 0;
  logic prev_req = 1'b0;

  // reference model state: sequence phase, ticks remaining, recovery phase
  int mp, mleft, rp, rleft;
  bit mup;

  always #10 clk = ~clk;

  link_bringup_mon u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .dbg_word0(dbg_word0),
    .dbg_word1(dbg_word1), .phy_rx_valid(phy_rx_valid), .gen2_start(gen2_start),
    .ovr_done(ovr_done), .phy_rst(phy_rst), .phy_pwrdn(phy_pwrdn),
    .perst_n(perst_n), .ltssm_en(ltssm_en), .link_up(link_up),
    .link_fail(link_fail), .ovr_req(ovr_req), .ovr_en(ovr_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  function automatic int phase_len(input int p);
    case (p)
      0: return 30;
      1: return 1;
      2: return 20;
      default: return 200;
    endcase
  endfunction

  // tick divider and handshake responder, driven off the falling edge
  always @(negedge clk) begin
    #2;
    tdiv    = (tdiv + 1) % 4;
    ms_tick = (tdiv == 0);
    ovr_done = ovr_req && !ovr_done;
  end

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mp = 0; mleft = 30; rp = 0; rleft = 0; mup = 0;
    end else begin
      bit lok, stuck;
      lok   = dbg_word1[4] && !dbg_word1[29];
      stuck = (dbg_word0[5:0] == 6'h0D) && !phy_rx_valid;
      case (rp)
        0: if (gen2_start && mp == 4) begin rp = 1; rleft = 2; end
        1: if (ms_tick) begin rleft--; if (rleft == 0) rp = stuck ? 2 : 0; end
        2: if (ovr_done) begin rp = 3; rleft = 1; end
        3: if (ms_tick) begin rleft--; if (rleft == 0) rp = 4; end
        default: if (ovr_done) rp = 0;
      endcase
      mup = (mp == 3 || mp == 4) && lok;
      if (mp <= 2) begin
        if (ms_tick) begin
          mleft--;
          if (mleft == 0) begin mp++; mleft = phase_len(mp); end
        end
      end else if (mp == 3) begin
        if (lok) mp = 4;
        else if (ms_tick) begin mleft--; if (mleft == 0) mp = 5; end
      end
    end
  end

  // per-cycle comparison on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (ovr_req && !prev_req) req_rises++;
    prev_req = ovr_req;
    chk("R2 phy_rst",   phy_rst,   mp == 0);
    chk("R2 phy_pwrdn", phy_pwrdn, mp == 0);
    chk("R3 perst_n",   perst_n,   mp >= 2);
    chk("R5 ltssm_en",  ltssm_en,  mp == 3 || mp == 4);
    chk("R6 link_fail", link_fail, mp == 5);
    chk("R1 link_up",   link_up,   mup);
    chk("R8 ovr_req",   ovr_req,   rp == 2 || rp == 4);
    chk("R9 ovr_en",    ovr_en,    (rp == 2 || rp == 3) ? 2'b11 : 2'b00);
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #3;
  endtask

  task automatic pulse_gen2();
    gen2_start = 1'b1;
    step(1);
    gen2_start = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    int r0;
    forever begin
      @(posedge clk);
      if (cyc > 20000) begin
        n_bad++;
        $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
        finish_run();
      end
    end
  end

  initial begin
    int w;
    rst_n = 1'b0; ms_tick = 1'b0; ovr_done = 1'b0; gen2_start = 1'b0;
    dbg_word0 = '0; dbg_word1 = 32'h2000_0010; phy_rx_valid = 1'b1;
    step(3);
    chk("R2 reset phy_rst", phy_rst, 1'b1);
    chk("R2 reset perst_n", perst_n, 1'b0);
    rst_n = 1'b1;
    step(5);
    // R10: speed change request during reset settle is ignored
    pulse_gen2();
    step(20);
    chk("R10 no request before link-up", req_rises, 0);
    w = 0;
    while (!perst_n && w < 1000) begin step(1); w++; end
    step(2);
    chk("R4 holdoff keeps training off", ltssm_en, 1'b0);
    chk("R4 holdoff perst released", perst_n, 1'b1);
    // R1: link-up bit with training bit set is not link-up; R6 fail path
    w = 0;
    while (!link_fail && w < 2000) begin step(1); w++; end
    chk("R6 link_fail latched", link_fail, 1'b1);
    chk("R1 no link-up while training bit set", link_up, 1'b0);

    // second bring-up, link comes up
    rst_n = 1'b0; dbg_word1 = '0;
    step(2);
    rst_n = 1'b1;
    w = 0;
    while (!ltssm_en && w < 1000) begin step(1); w++; end
    chk("R5 training enabled", ltssm_en, 1'b1);
    step(9);
    dbg_word1 = 32'h0000_0010;
    step(2);
    chk("R1 link up decoded", link_up, 1'b1);

    // R7/R8/R9: stuck in receiver lock with receive-valid low
    dbg_word0 = 32'h0000_000D; phy_rx_valid = 1'b0;
    pulse_gen2();
    w = 0;
    while (!ovr_req && w < 100) begin step(1); w++; end
    chk("R7 stuck detected", ovr_req, 1'b1);
    chk("R8 set value", ovr_en, 2'b11);
    step(2);
    pulse_gen2(); // R10: ignored while override held
    step(40);
    chk("R9 two requests (set then clear)", req_rises, 2);
    chk("R9 overrides cleared", ovr_en, 2'b00);

    // R11: receive-valid high, not stuck
    phy_rx_valid = 1'b1;
    pulse_gen2();
    step(30);
    chk("R11 rx valid, no request", req_rises, 2);
    // R11: different link state code
    dbg_word0 = 32'h0000_0011; phy_rx_valid = 1'b0;
    pulse_gen2();
    step(30);
    chk("R11 other state, no request", req_rises, 2);

    // edges sweep: stuck condition toggling across tick phases
    dbg_word0 = 32'h0000_000D;
    for (int k = 0; k < 4; k++) begin
      pulse_gen2();
      step(k + 4);
      phy_rx_valid = ~phy_rx_valid;
      step(40);
    end

    // R1: training bit returns, link_up drops
    dbg_word1 = 32'h2000_0010;
    step(3);
    chk("R1 link-up drops on training bit", link_up, 1'b0);
    step(5);
    finish_run();
  end

endmodule